// File: doc/BRIEF.md
# Link-Quality Receiver Mode Controller

This block sits in a digital baseband and sets the receiver's power/performance mode while a packet is being received. It takes the in-channel power of each sample, as measured after the channel filter, and averages it over a window of 2^k samples. At the end of each window it compares the average against the sum of its own noise-floor estimate and an externally supplied estimate of the residual adjacent-channel interference. The quantity it evaluates is the power in excess of that floor, divided by the floor. Because the division is folded into a multiply, no divider is needed.

The block builds the noise-floor estimate from in-channel power observed while no packet is present. The estimate is a shift-based exponential average, and it is held constant during a packet. Two programmable fixed-point thresholds split the metric into three bands. A strong link selects the low-power mode and a weak link selects the high-performance mode. The decision is taken again after every window, so the mode can move several times within one packet. Each new packet starts in high-performance mode.

Top module: `lq_mode_ctrl`

## Requirements
- R1: While reset is held and after its release, before any window completes, `mode_o` is 2'b00 (high performance) and `mode_valid_o` is 0.
- R2: The first in-channel sample with `pwr_valid_i`=1 and `pkt_active_i`=0 after reset loads the floor estimate N directly. Every later such sample P moves N toward P by |P−N| shifted right by `NF_SHIFT` (3 by default), truncated.
- R3: Samples taken while `pkt_active_i`=1 leave N unchanged.
- R4: A decision is issued after every 2^`win_log2_i` valid in-packet samples. `mode_o` updates and `mode_valid_o` pulses high for one cycle on the second rising edge after the edge that takes the last sample of the window.
- R5: With A = (window sum) >> k, floor F = N + `intf_i`, and thresholds in unsigned fixed point with `FRAC` (8) fractional bits: if A·2^FRAC > (2^FRAC + `th_high_i`)·F, the mode becomes 2'b10 (low performance, lowest power).
- R6: Otherwise, if A·2^FRAC < (2^FRAC + `th_low_i`)·F, the mode becomes 2'b00 (high performance).
- R7: Otherwise the mode becomes 2'b01 (moderate). This includes exact equality with either bound. Code 2'b11 never appears.
- R8: On the first cycle in which `pkt_active_i` is high, the mode returns to 2'b00 with no strobe. Any partial window from an earlier packet is discarded.
- R9: The mode is re-evaluated at every window within a packet and can change mid-packet in either direction.
- R10: Cycles with `pwr_valid_i`=0 and samples taken outside a packet do not count toward a window, whatever `pwr_i` carries.
- R11: If `th_low_i` exceeds `th_high_i` and both comparisons hold, the low-performance mode (R5) wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_i | input | PW | In-channel power of the current sample |
| pwr_valid_i | input | 1 | `pwr_i` carries a sample this cycle |
| pkt_active_i | input | 1 | A packet is being received |
| intf_i | input | PW | Residual adjacent-channel interference estimate |
| th_low_i | input | TW | Lower metric threshold, FRAC fractional bits (default 512 ≈ 2.0) |
| th_high_i | input | TW | Upper metric threshold, FRAC fractional bits (default 2033 ≈ 7.94) |
| win_log2_i | input | KW | Window length exponent k |
| mode_o | output | 2 | 00 high, 01 moderate, 10 low performance |
| mode_valid_o | output | 1 | One-cycle strobe for a new decision |

## Verification
The result of a window appears two rising edges after its last valid sample. The bench therefore checks that the strobe is still low at the first falling edge after that sample, and checks both the strobe and the mode at the second falling edge. At the third falling edge it checks that the strobe has dropped again. The floor update and the forced high-performance mode at packet start each take effect on the very next edge. The bench drives an idle cycle before the first window sample, so each R8 check falls on the falling edge directly after the edge that sees the packet begin. Expected modes come from a bench model of the averaging, the floor and the cross-multiplied comparisons. That model also covers exact-equality windows, inverted thresholds, and inputs injected into gaps or outside packets.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef enum logic [1:0] {
    MODE_HIGH = 2'b00,
    MODE_MID  = 2'b01,
    MODE_LOW  = 2'b10
  } lq_mode_e;

  // default thresholds for FRAC = 8: 3 dB and 9 dB SINR
  localparam int unsigned TH_LOW_DEF  = 512;
  localparam int unsigned TH_HIGH_DEF = 2033;
endpackage

// File: rtl/lq_noise_floor.sv
module lq_noise_floor #(
  parameter int unsigned PW       = 16,
  parameter int unsigned NF_SHIFT = 3,
  parameter bit          NF_SEED  = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pwr_i,
  input  logic          upd_i,
  output logic [PW-1:0] nf_o
);
  logic [PW-1:0] nf_q, nf_nxt, nf_ema, step_up, step_dn;

  always_comb begin
    step_up = (pwr_i - nf_q) >> NF_SHIFT;
    step_dn = (nf_q - pwr_i) >> NF_SHIFT;
    nf_ema  = (pwr_i >= nf_q) ? (nf_q + step_up) : (nf_q - step_dn);
  end

  generate
    if (NF_SEED) begin : g_seed
      logic seeded_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    seeded_q <= 1'b0;
        else if (upd_i) seeded_q <= 1'b1;
      end
      assign nf_nxt = seeded_q ? nf_ema : pwr_i;
    end else begin : g_plain
      assign nf_nxt = nf_ema;
    end
  endgenerate

  // frozen whenever upd_i is low (packet active)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    nf_q <= '0;
    else if (upd_i) nf_q <= nf_nxt;
  end

  assign nf_o = nf_q;
endmodule

// File: rtl/lq_win_acc.sv
module lq_win_acc #(
  parameter int unsigned PW = 16,
  parameter int unsigned KW = 3,
  localparam int unsigned KMAX = (1 << KW) - 1,
  localparam int unsigned SW   = PW + KMAX,
  localparam int unsigned CW   = KMAX
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pwr_i,
  input  logic          smp_i,
  input  logic          pkt_i,
  input  logic [KW-1:0] k_i,
  output logic [SW-1:0] avg_o,
  output logic          avg_vld_o
);
  logic [CW-1:0] cnt_q, last_cnt;
  logic [SW-1:0] sum_q, sum_nxt, avg_q;
  logic          vld_q;

  always_comb begin
    last_cnt = ~({CW{1'b1}} << k_i);
    sum_nxt  = sum_q + SW'(pwr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sum_q <= '0;
      avg_q <= '0;
      vld_q <= 1'b0;
    end else if (!pkt_i) begin
      cnt_q <= '0;
      sum_q <= '0;
      vld_q <= 1'b0;
    end else if (smp_i) begin
      if (cnt_q == last_cnt) begin
        avg_q <= sum_nxt >> k_i;
        vld_q <= 1'b1;
        cnt_q <= '0;
        sum_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sum_q <= sum_nxt;
        vld_q <= 1'b0;
      end
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign avg_o     = avg_q;
  assign avg_vld_o = vld_q;
endmodule

// File: rtl/lq_decide.sv
module lq_decide import lq_pkg::*; #(
  parameter int unsigned PW   = 16,
  parameter int unsigned SW   = 23,
  parameter int unsigned TW   = 12,
  parameter int unsigned FRAC = 8,
  localparam int unsigned FW  = PW + 1,
  localparam int unsigned MW  = TW + 1,
  localparam int unsigned PRW = FW + MW,
  localparam int unsigned LW  = SW + FRAC,
  localparam int unsigned XW  = (PRW > LW) ? PRW : LW,
  localparam int unsigned ONE = 1 << FRAC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] avg_i,
  input  logic          avg_vld_i,
  input  logic          pkt_i,
  input  logic [PW-1:0] nf_i,
  input  logic [PW-1:0] intf_i,
  input  logic [TW-1:0] th_low_i,
  input  logic [TW-1:0] th_high_i,
  output lq_mode_e      mode_o,
  output logic          mode_valid_o
);
  logic [FW-1:0] floor_w;
  logic [MW-1:0] g_lo, g_hi;
  logic [XW-1:0] lhs, rhs_lo, rhs_hi;
  lq_mode_e      dec;
  lq_mode_e      mode_q;
  logic          mv_q, pkt_q, start;

  // metric > th  <=>  A*ONE > (ONE + th) * (N + I)
  always_comb begin
    floor_w = FW'(nf_i) + FW'(intf_i);
    g_lo    = MW'(th_low_i) + MW'(ONE);
    g_hi    = MW'(th_high_i) + MW'(ONE);
    lhs     = XW'({avg_i, {FRAC{1'b0}}});
    rhs_lo  = XW'(g_lo) * XW'(floor_w);
    rhs_hi  = XW'(g_hi) * XW'(floor_w);
    if (lhs > rhs_hi)      dec = MODE_LOW;
    else if (lhs < rhs_lo) dec = MODE_HIGH;
    else                   dec = MODE_MID;
  end

  assign start = pkt_i & ~pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q  <= 1'b0;
      mode_q <= MODE_HIGH;
      mv_q   <= 1'b0;
    end else begin
      pkt_q <= pkt_i;
      if (start) begin
        mode_q <= MODE_HIGH;
        mv_q   <= 1'b0;
      end else if (avg_vld_i) begin
        mode_q <= dec;
        mv_q   <= 1'b1;
      end else begin
        mv_q   <= 1'b0;
      end
    end
  end

  assign mode_o       = mode_q;
  assign mode_valid_o = mv_q;
endmodule

// File: rtl/lq_mode_ctrl.sv
module lq_mode_ctrl import lq_pkg::*; #(
  parameter int unsigned PW       = 16,
  parameter int unsigned TW       = 12,
  parameter int unsigned FRAC     = 8,
  parameter int unsigned KW       = 3,
  parameter int unsigned NF_SHIFT = 3,
  parameter bit          NF_SEED  = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pwr_i,
  input  logic          pwr_valid_i,
  input  logic          pkt_active_i,
  input  logic [PW-1:0] intf_i,
  input  logic [TW-1:0] th_low_i,
  input  logic [TW-1:0] th_high_i,
  input  logic [KW-1:0] win_log2_i,
  output logic [1:0]    mode_o,
  output logic          mode_valid_o
);
  localparam int unsigned KMAX = (1 << KW) - 1;
  localparam int unsigned SW   = PW + KMAX;

  logic [PW-1:0] nf_w;
  logic [SW-1:0] avg_w;
  logic          avg_vld_w, smp_w, upd_w;
  lq_mode_e      mode_w;

  assign smp_w = pwr_valid_i & pkt_active_i;
  assign upd_w = pwr_valid_i & ~pkt_active_i;

  lq_noise_floor #(.PW(PW), .NF_SHIFT(NF_SHIFT), .NF_SEED(NF_SEED)) u_nf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pwr_i (pwr_i),
    .upd_i (upd_w),
    .nf_o  (nf_w)
  );

  lq_win_acc #(.PW(PW), .KW(KW)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_i    (pwr_i),
    .smp_i    (smp_w),
    .pkt_i    (pkt_active_i),
    .k_i      (win_log2_i),
    .avg_o    (avg_w),
    .avg_vld_o(avg_vld_w)
  );

  lq_decide #(.PW(PW), .SW(SW), .TW(TW), .FRAC(FRAC)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .avg_i       (avg_w),
    .avg_vld_i   (avg_vld_w),
    .pkt_i       (pkt_active_i),
    .nf_i        (nf_w),
    .intf_i      (intf_i),
    .th_low_i    (th_low_i),
    .th_high_i   (th_high_i),
    .mode_o      (mode_w),
    .mode_valid_o(mode_valid_o)
  );

  assign mode_o = mode_w;
endmodule

// File: rtl/lq_mode_ctrl_chk.sv
module lq_mode_ctrl_chk #(
  parameter int unsigned PW = 16,
  parameter int unsigned KW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pkt_active_i,
  input logic [KW-1:0] win_log2_i,
  input logic [1:0]    mode_o,
  input logic          mode_valid_o,
  input logic [PW-1:0] nf_i
);
  assert_legal_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  assert_pkt_start_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pkt_active_i) |=> (mode_o == 2'b00 && !mode_valid_o));

  assert_nf_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_active_i |=> $stable(nf_i));

  assert_strobe_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_valid_o && win_log2_i != '0) |=> !mode_valid_o);

  assert_mode_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> (mode_valid_o || mode_o == 2'b00));
endmodule

bind lq_mode_ctrl lq_mode_ctrl_chk #(.PW(PW), .KW(KW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pkt_active_i(pkt_active_i),
  .win_log2_i  (win_log2_i),
  .mode_o      (mode_o),
  .mode_valid_o(mode_valid_o),
  .nf_i        (nf_w)
);

// File: tb/tb_lq_mode_ctrl.sv
module tb_lq_mode_ctrl;
  localparam int PW = 16, TW = 12, FRAC = 8, KW = 3, SH = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [PW-1:0] pwr = '0, intf = '0;
  logic pwr_valid = 1'b0, pkt = 1'b0;
  logic [TW-1:0] thl = TW'(512), thh = TW'(2033);
  logic [KW-1:0] k = '0;
  logic [1:0] mode;
  logic mode_valid;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  longint nf_m = 0;
  bit seeded_m = 1'b0;

  always #4 clk = ~clk;

  lq_mode_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_i(pwr), .pwr_valid_i(pwr_valid),
    .pkt_active_i(pkt), .intf_i(intf), .th_low_i(thl), .th_high_i(thh),
    .win_log2_i(k), .mode_o(mode), .mode_valid_o(mode_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int decide(input longint avg);
    longint lhs, fl, lo, hi;
    lhs = avg * 256;
    fl  = nf_m + longint'(intf);
    lo  = (256 + longint'(thl)) * fl;
    hi  = (256 + longint'(thh)) * fl;
    if (lhs > hi) return 2;
    if (lhs < lo) return 0;
    return 1;
  endfunction

  // idle sample: updates noise floor (R2)
  task automatic idle(input int p);
    @(negedge clk);
    pkt = 1'b0; pwr_valid = 1'b1; pwr = PW'(p);
    if (!seeded_m) begin nf_m = p; seeded_m = 1'b1; end
    else if (p >= nf_m) nf_m = nf_m + ((p - nf_m) >> SH);
    else nf_m = nf_m - ((nf_m - p) >> SH);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pwr_valid = 1'b0; pwr = PW'($urandom);
    end
  endtask

  task automatic pkt_begin();
    @(negedge clk);
    pkt = 1'b1; pwr_valid = 1'b0;
    @(negedge clk);
    chk(mode == 2'b00, "R8 start mode", mode, 0);
    chk(mode_valid == 1'b0, "R8 start strobe", mode_valid, 0);
  endtask

  task automatic pkt_end();
    @(negedge clk);
    pkt = 1'b0; pwr_valid = 1'b0;
  endtask

  // one full window; returns expected mode
  task automatic window(input int kk, input int base, input int jit, input bit holes,
                        input string tag, output int expm);
    longint sum = 0;
    int v;
    k = KW'(kk);
    for (int i = 0; i < (1 << kk); i++) begin
      if (holes) begin
        @(negedge clk);
        pwr_valid = 1'b0; pwr = 16'hffff; // R10 ignored
      end
      @(negedge clk);
      v = base + ((jit > 0) ? int'($urandom % (jit + 1)) : 0);
      if (v > 65535) v = 65535;
      pwr_valid = 1'b1; pwr = PW'(v);
      sum += v;
    end
    expm = decide(sum >> kk);
    @(negedge clk);
    pwr_valid = 1'b0;
    chk(mode_valid == 1'b0, {tag, " R4 early strobe"}, mode_valid, 0);
    @(negedge clk);
    chk(mode_valid == 1'b1, {tag, " R4 strobe"}, mode_valid, 1);
    chk(int'(mode) == expm, {tag, " mode"}, mode, expm);
    @(negedge clk);
    chk(mode_valid == 1'b0, {tag, " R4 pulse end"}, mode_valid, 0);
  endtask

  function automatic string tag_of(input int m);
    return (m == 2) ? "R5" : (m == 0) ? "R6" : "R7";
  endfunction

  initial begin
    int e, seed, fl;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk(mode == 2'b00 && mode_valid == 1'b0, "R1 in reset", {mode, mode_valid}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(mode == 2'b00 && mode_valid == 1'b0, "R1 after reset", {mode, mode_valid}, 0);

    // seed floor N=100, I=0 (R2)
    idle(100); gap(1);
    pkt_begin();
    window(0, 300, 0, 0, "R7 equal low bound", e);
    chk(e == 1, "R7 model", e, 1);
    window(0, 299, 0, 0, "R6 just below", e);
    window(0, 894, 0, 0, "R7 just under upper", e);
    window(0, 895, 0, 0, "R5 just above", e);
    chk(e == 2, "R5 model", e, 2);
    window(0, 150, 0, 0, "R9 back to high", e);
    chk(mode == 2'b00, "R9 mid-packet change", mode, 0);
    pkt_end();

    // EMA in both directions (R2), interference added
    idle(180); idle(20); gap(1);
    intf = PW'(50);
    pkt_begin();
    window(2, 400, 40, 0, "R2 ema decision", e);
    // huge in-packet samples must not move N (R3)
    window(1, 60000, 100, 0, "R3 strong window", e);
    window(2, 420, 20, 0, "R3 floor held", e);
    // gaps with garbage do not count (R10)
    window(2, 700, 30, 1, "R10 holes", e);
    // partial window then packet ends (R8)
    k = KW'(2);
    @(negedge clk); pwr_valid = 1'b1; pwr = PW'(65000);
    @(negedge clk); pwr_valid = 1'b1; pwr = PW'(65000);
    pkt_end();
    gap(1);
    chk(mode_valid == 1'b0, "R10 no strobe outside packet", mode_valid, 0);
    pkt_begin();
    window(2, 200, 10, 0, "R8 fresh window", e);
    pkt_end();

    // inverted thresholds: low wins (R11)
    thl = TW'(3000); thh = TW'(100);
    pkt_begin();
    fl = int'(nf_m) + int'(intf);
    window(0, fl * 5, 0, 0, "R11 priority", e);
    chk(e == 2, "R11 model", e, 2);
    pkt_end();

    // random phase
    for (int p = 0; p < 30; p++) begin
      thl = TW'(128 + ($urandom % 800));
      thh = TW'(int'(thl) + ($urandom % 2500));
      intf = PW'($urandom % 400);
      for (int j = 0; j < 3; j++) idle(50 + ($urandom % 900));
      gap(1);
      pkt_begin();
      for (int w = 0; w < 3; w++) begin
        int kk, base, m;
        kk = int'($urandom % 5);
        fl = int'(nf_m) + int'(intf);
        base = (fl * int'($urandom % 60)) / 4;
        m = decide(base);
        window(kk, base, fl / 8, ($urandom % 4) == 0, tag_of(m), e);
      end
      pkt_end();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4 watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule